// File: doc/BRIEF.md
# Transactional Read/Write Set Tracker

This block sits between one local requester and a small backing memory. It lets that requester run a group of loads and stores as one atomic transaction. A begin command opens a transaction. While it is open, each line that a load touches is entered into a small fully associative tracking table with a read mark. Each line that a store touches is entered with a write mark and the stored word. The stored word stays in the table, and the backing memory does not see it while the transaction runs. A later load of a line that was written returns the word held in the table.

Other agents report the line addresses they touch on a snoop port. A snoop that collides with the tracked sets aborts the transaction. Other causes also abort it: a ninth distinct line, an asynchronous trap, a debug trap, or an explicit abort command. On abort the buffered stores are discarded and the block reports a status word with one flag per reason. On an end command with no abort, the buffered stores are written to memory on consecutive cycles. The snoop port is stalled during this drain, so other agents see every store appear at the same point.

Outside a transaction, loads and stores pass straight through to the memory. One line holds exactly one 32-bit word, so a line address is a word address.

Top module: `txn_tracker`

## Requirements
- R1: One cycle after `cmd_begin` in the idle state, `status_valid` pulses with `status_word` = 0xFFFF_FFFF (started). Every abort word has bits 23:5 equal to zero, so no abort word can equal the started word.
- R2: While a transaction is open, stores do not assert `mem_wr_en`. A load of a line stored earlier in the same transaction returns the stored word. A load of any other line returns the memory word. Each load response comes one cycle after the request.
- R3: A snoop of a line in the write set aborts the transaction with the conflict flag (bit 1), whatever the snoop kind (`snoop_write` 0 or 1). A snoop with `snoop_write`=1 of a line in the read set also aborts with bit 1. A snoop with `snoop_write`=0 of a line that is only read causes no abort.
- R4: A load or store to a new line when all 8 table entries are in use aborts with the capacity flag (bit 2), and that access produces no response.
- R5: `evt_trap` during a transaction aborts it with bit 4 set. `evt_debug` during a transaction aborts it with bit 3 set.
- R6: `cmd_abort` during a transaction aborts with bit 0 set. Bits 31:24 then carry `abort_code`. Those bits are zero for every other abort.
- R7: After any abort, memory holds its values from before the transaction, and a load returns those values.
- R8: `cmd_end` with buffered stores writes one store per cycle to memory with `snoop_stall` high on each of those cycles. `done` pulses for one cycle, exactly one cycle after the last write. `cmd_end` with no stores pulses `done` on the next cycle and writes nothing.
- R9: A conflicting snoop in the same cycle as `cmd_end` aborts with the conflict flag. `done` does not pulse and nothing is written.
- R10: Commit and abort both clear the table. The next transaction can use all 8 entries without a capacity abort.
- R11: In the idle state, a store writes memory in the same cycle it is presented, and a load returns the memory word one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_begin | input | 1 | Open a transaction |
| cmd_end | input | 1 | Request commit of the open transaction |
| cmd_abort | input | 1 | Explicit abort of the open transaction |
| abort_code | input | 8 | Code reported with an explicit abort |
| evt_trap | input | 1 | Interrupt, fault or system call occurred |
| evt_debug | input | 1 | Debug trap occurred |
| req_valid | input | 1 | Load/store request present |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | ADDR_W | Line address |
| req_wdata | input | 32 | Store data |
| req_ready | output | 1 | Low while committed stores drain |
| rsp_valid | output | 1 | Load response valid |
| rsp_rdata | output | 32 | Load response data |
| snoop_valid | input | 1 | Another agent touched a line |
| snoop_write | input | 1 | The foreign access was a write |
| snoop_addr | input | ADDR_W | Line address of the foreign access |
| snoop_stall | output | 1 | Snoops are held off (drain in progress) |
| mem_rd_addr | output | ADDR_W | Memory read address (combinational) |
| mem_rd_data | input | 32 | Memory read data, same cycle |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | 32 | Memory write data |
| status_valid | output | 1 | Started or abort status pulse |
| status_word | output | 32 | Started word or abort reason flags and code |
| done | output | 1 | Commit finished pulse |

## Verification
The properties assume that the requester issues at most one command per cycle and never asserts `cmd_begin` while a transaction is open. They also assume that no request shares a cycle with a command, that no request is issued while `req_ready` is low, and that the snoop source sends nothing while `snoop_stall` is high. Directed tasks keep within these limits: each drives a single command or access for exactly one cycle, and between steps every input is returned to zero. The only deliberate overlap is a snoop together with `cmd_end`, which the block defines.

// File: rtl/txn_pkg.sv
package txn_pkg;
  localparam int DATA_W = 32;
  localparam int CODE_W = 8;

  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_ACTIVE = 2'd1,
    TX_DRAIN  = 2'd2
  } txn_state_t;

  // bit 4 trap, bit 3 debug, bit 2 capacity, bit 1 conflict, bit 0 explicit
  typedef struct packed {
    logic trap;
    logic debug;
    logic capacity;
    logic conflict;
    logic expl;
  } abort_flags_t;

  localparam logic [DATA_W-1:0] STATUS_STARTED = 32'hFFFF_FFFF;

  function automatic logic [DATA_W-1:0] abort_word(input abort_flags_t f,
                                                   input logic [CODE_W-1:0] code);
    logic [CODE_W-1:0] c;
    c = f.expl ? code : '0;
    return {c, 19'd0, f};
  endfunction

  // A foreign access collides with a written line always, with a read line only if it writes
  function automatic logic snoop_collides(input logic foreign_write,
                                          input logic in_read_set,
                                          input logic in_write_set);
    return in_write_set || (foreign_write && in_read_set);
  endfunction
endpackage

// File: rtl/txn_entry_table.sv
module txn_entry_table
  import txn_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear_all,
  input  logic              acc_en,
  input  logic              acc_write,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [DATA_W-1:0] acc_wdata,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              drain_en,
  output logic              lk_hit,
  output logic              lk_hit_w,
  output logic [DATA_W-1:0] lk_data,
  output logic              lk_nospace,
  output logic              snp_in_rd,
  output logic              snp_in_wr,
  output logic              drain_any,
  output logic              drain_last,
  output logic [ADDR_W-1:0] drain_addr,
  output logic [DATA_W-1:0] drain_data
);
  localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
  localparam int CNT_W = $clog2(ENTRIES + 1);

  logic              vld  [ENTRIES];
  logic              rbit [ENTRIES];
  logic              wbit [ENTRIES];
  logic [ADDR_W-1:0] tag  [ENTRIES];
  logic [DATA_W-1:0] dat  [ENTRIES];

  logic [ENTRIES-1:0] vld_v, rbit_v, wbit_v, lk_match, snp_match;
  logic [IDX_W-1:0]   hit_idx, free_idx, drain_idx, tgt_idx;

  function automatic logic [IDX_W-1:0] lowest_set(input logic [ENTRIES-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  function automatic logic [CNT_W-1:0] ones(input logic [ENTRIES-1:0] v);
    logic [CNT_W-1:0] n;
    n = '0;
    for (int i = 0; i < ENTRIES; i++) n = n + CNT_W'(v[i]);
    return n;
  endfunction

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign vld_v[g]     = vld[g];
    assign rbit_v[g]    = rbit[g];
    assign wbit_v[g]    = wbit[g];
    assign lk_match[g]  = vld[g] && (tag[g] == acc_addr);
    assign snp_match[g] = vld[g] && (tag[g] == snp_addr);
  end

  always_comb begin
    hit_idx    = lowest_set(lk_match);
    free_idx   = lowest_set(~vld_v);
    drain_idx  = lowest_set(wbit_v);
    lk_hit     = |lk_match;
    lk_hit_w   = |(lk_match & wbit_v);
    lk_data    = dat[hit_idx];
    lk_nospace = !lk_hit && (&vld_v);
    snp_in_rd  = |(snp_match & rbit_v);
    snp_in_wr  = |(snp_match & wbit_v);
    drain_any  = |wbit_v;
    drain_last = (ones(wbit_v) == CNT_W'(1));
    drain_addr = tag[drain_idx];
    drain_data = dat[drain_idx];
    tgt_idx    = lk_hit ? hit_idx : free_idx;
  end

  for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        vld[g]  <= 1'b0;
        rbit[g] <= 1'b0;
        wbit[g] <= 1'b0;
        tag[g]  <= '0;
        dat[g]  <= '0;
      end else if (clear_all) begin
        vld[g]  <= 1'b0;
        rbit[g] <= 1'b0;
        wbit[g] <= 1'b0;
      end else begin
        if (drain_en && (drain_idx == IDX_W'(g))) wbit[g] <= 1'b0;
        if (acc_en && !lk_nospace && (tgt_idx == IDX_W'(g))) begin
          vld[g] <= 1'b1;
          tag[g] <= acc_addr;
          if (acc_write) begin
            wbit[g] <= 1'b1;
            dat[g]  <= acc_wdata;
          end else begin
            rbit[g] <= 1'b1;
          end
        end
      end
    end
  end
endmodule

// File: rtl/txn_snoop_check.sv
module txn_snoop_check
  import txn_pkg::*;
(
  input  logic snoop_valid,
  input  logic snoop_write,
  input  logic snp_in_rd,
  input  logic snp_in_wr,
  output logic conflict_hit
);
  always_comb begin
    conflict_hit = snoop_valid && snoop_collides(snoop_write, snp_in_rd, snp_in_wr);
  end
endmodule

// File: rtl/txn_ctrl.sv
module txn_ctrl
  import txn_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_begin,
  input  logic              cmd_end,
  input  logic              cmd_abort,
  input  logic [CODE_W-1:0] abort_code,
  input  logic              evt_trap,
  input  logic              evt_debug,
  input  logic              req_valid,
  input  logic              conflict_hit,
  input  logic              lk_nospace,
  input  logic              drain_any,
  input  logic              drain_last,
  output txn_state_t        state,
  output logic              acc_en,
  output logic              pass_en,
  output logic              clear_all,
  output logic              drain_en,
  output logic              abort_fire,
  output logic              cap_overflow,
  output logic              status_valid,
  output logic [DATA_W-1:0] status_word,
  output logic              done
);
  abort_flags_t flags;
  logic any_cmd, active, req_go, commit_go;

  always_comb begin
    any_cmd      = cmd_begin || cmd_end || cmd_abort;
    active       = (state == TX_ACTIVE);
    req_go       = req_valid && !any_cmd;
    cap_overflow = active && req_go && lk_nospace;
    flags.trap     = active && evt_trap;
    flags.debug    = active && evt_debug;
    flags.capacity = cap_overflow;
    flags.conflict = active && conflict_hit;
    flags.expl     = active && cmd_abort;
    abort_fire   = |flags;
    commit_go    = active && cmd_end && !abort_fire;
    acc_en       = active && req_go && !abort_fire;
    pass_en      = (state == TX_IDLE) && req_go;
    drain_en     = (state == TX_DRAIN);
    clear_all    = abort_fire || (commit_go && !drain_any) || (drain_en && drain_last);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= TX_IDLE;
      status_valid <= 1'b0;
      status_word  <= '0;
      done         <= 1'b0;
    end else begin
      status_valid <= 1'b0;
      done         <= 1'b0;
      unique case (state)
        TX_IDLE: begin
          if (cmd_begin) begin
            state        <= TX_ACTIVE;
            status_valid <= 1'b1;
            status_word  <= STATUS_STARTED;
          end
        end
        TX_ACTIVE: begin
          if (abort_fire) begin
            state        <= TX_IDLE;
            status_valid <= 1'b1;
            status_word  <= abort_word(flags, abort_code);
          end else if (commit_go) begin
            if (drain_any) begin
              state <= TX_DRAIN;
            end else begin
              state <= TX_IDLE;
              done  <= 1'b1;
            end
          end
        end
        TX_DRAIN: begin
          if (drain_last) begin
            state <= TX_IDLE;
            done  <= 1'b1;
          end
        end
        default: state <= TX_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txn_tracker.sv
module txn_tracker
  import txn_pkg::*;
#(
  parameter int ENTRIES = 8,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_begin,
  input  logic              cmd_end,
  input  logic              cmd_abort,
  input  logic [7:0]        abort_code,
  input  logic              evt_trap,
  input  logic              evt_debug,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  input  logic              snoop_valid,
  input  logic              snoop_write,
  input  logic [ADDR_W-1:0] snoop_addr,
  output logic              snoop_stall,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic [31:0]       mem_rd_data,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_wr_addr,
  output logic [31:0]       mem_wr_data,
  output logic              status_valid,
  output logic [31:0]       status_word,
  output logic              done
);
  txn_state_t        state;
  logic              acc_en, pass_en, clear_all, drain_en, abort_fire, cap_overflow;
  logic              lk_hit, lk_hit_w, lk_nospace, snp_in_rd, snp_in_wr;
  logic              drain_any, drain_last, conflict_hit, drain_last_fire;
  logic [DATA_W-1:0] lk_data, drain_data;
  logic [ADDR_W-1:0] drain_addr;

  txn_entry_table #(.ENTRIES(ENTRIES), .ADDR_W(ADDR_W)) u_table (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_all  (clear_all),
    .acc_en     (acc_en),
    .acc_write  (req_write),
    .acc_addr   (req_addr),
    .acc_wdata  (req_wdata),
    .snp_addr   (snoop_addr),
    .drain_en   (drain_en),
    .lk_hit     (lk_hit),
    .lk_hit_w   (lk_hit_w),
    .lk_data    (lk_data),
    .lk_nospace (lk_nospace),
    .snp_in_rd  (snp_in_rd),
    .snp_in_wr  (snp_in_wr),
    .drain_any  (drain_any),
    .drain_last (drain_last),
    .drain_addr (drain_addr),
    .drain_data (drain_data)
  );

  txn_snoop_check u_snoop (
    .snoop_valid  (snoop_valid),
    .snoop_write  (snoop_write),
    .snp_in_rd    (snp_in_rd),
    .snp_in_wr    (snp_in_wr),
    .conflict_hit (conflict_hit)
  );

  txn_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_begin    (cmd_begin),
    .cmd_end      (cmd_end),
    .cmd_abort    (cmd_abort),
    .abort_code   (abort_code),
    .evt_trap     (evt_trap),
    .evt_debug    (evt_debug),
    .req_valid    (req_valid),
    .conflict_hit (conflict_hit),
    .lk_nospace   (lk_nospace),
    .drain_any    (drain_any),
    .drain_last   (drain_last),
    .state        (state),
    .acc_en       (acc_en),
    .pass_en      (pass_en),
    .clear_all    (clear_all),
    .drain_en     (drain_en),
    .abort_fire   (abort_fire),
    .cap_overflow (cap_overflow),
    .status_valid (status_valid),
    .status_word  (status_word),
    .done         (done)
  );

  always_comb begin
    drain_last_fire = drain_en && drain_last;
    req_ready       = !drain_en;
    snoop_stall     = drain_en;
    mem_rd_addr     = req_addr;
    mem_wr_en       = drain_en || (pass_en && req_write);
    mem_wr_addr     = drain_en ? drain_addr : req_addr;
    mem_wr_data     = drain_en ? drain_data : req_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= (acc_en || pass_en) && !req_write;
      rsp_rdata <= (acc_en && lk_hit_w) ? lk_data : mem_rd_data;
    end
  end
endmodule

// File: rtl/txn_tracker_checker.sv
module txn_tracker_checker
  import txn_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input txn_state_t  state,
  input logic        cmd_begin,
  input logic        cmd_end,
  input logic        status_valid,
  input logic [31:0] status_word,
  input logic        mem_wr_en,
  input logic        snoop_stall,
  input logic        done,
  input logic        conflict_hit,
  input logic        cap_overflow,
  input logic        abort_fire,
  input logic        drain_last_fire
);
  a_r1_started_word: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_IDLE && cmd_begin) |=> (status_valid && status_word == STATUS_STARTED));

  a_r1_abort_shape: assert property (@(posedge clk) disable iff (!rst_n)
    (status_valid && status_word != STATUS_STARTED) |-> (status_word[23:5] == 19'd0));

  a_r2_hidden_stores: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_ACTIVE) |-> !mem_wr_en);

  a_r3_conflict_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_ACTIVE && conflict_hit) |=> (status_valid && status_word[1]));

  a_r4_capacity_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_ACTIVE && cap_overflow) |=> (status_valid && status_word[2]));

  a_r8_drain_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_DRAIN) |-> (snoop_stall && mem_wr_en));

  a_r8_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    drain_last_fire |=> (done && state == TX_IDLE));

  a_r9_end_with_snoop: assert property (@(posedge clk) disable iff (!rst_n)
    (state == TX_ACTIVE && cmd_end && conflict_hit) |=> (!done && status_word[1]));

  a_r10_idle_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
    abort_fire |=> (state == TX_IDLE));
endmodule

bind txn_tracker txn_tracker_checker u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .state           (state),
  .cmd_begin       (cmd_begin),
  .cmd_end         (cmd_end),
  .status_valid    (status_valid),
  .status_word     (status_word),
  .mem_wr_en       (mem_wr_en),
  .snoop_stall     (snoop_stall),
  .done            (done),
  .conflict_hit    (conflict_hit),
  .cap_overflow    (cap_overflow),
  .abort_fire      (abort_fire),
  .drain_last_fire (drain_last_fire)
);

// File: tb/txn_tracker_bench.sv
module txn_tracker_bench;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_begin = 0, cmd_end = 0, cmd_abort = 0, evt_trap = 0, evt_debug = 0;
  logic [7:0] abort_code = 0;
  logic req_valid = 0, req_write = 0;
  logic [AW-1:0] req_addr = 0;
  logic [31:0] req_wdata = 0;
  logic snoop_valid = 0, snoop_write = 0;
  logic [AW-1:0] snoop_addr = 0;
  logic req_ready, rsp_valid, snoop_stall, mem_wr_en, status_valid, done;
  logic [31:0] rsp_rdata, mem_rd_data, mem_wr_data, status_word;
  logic [AW-1:0] mem_rd_addr, mem_wr_addr;

  always #10 clk = ~clk;  // 50 MHz

  txn_tracker #(.ENTRIES(8), .ADDR_W(AW)) u_txn_tracker (
    .clk(clk), .rst_n(rst_n), .cmd_begin(cmd_begin), .cmd_end(cmd_end),
    .cmd_abort(cmd_abort), .abort_code(abort_code), .evt_trap(evt_trap),
    .evt_debug(evt_debug), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .snoop_valid(snoop_valid),
    .snoop_write(snoop_write), .snoop_addr(snoop_addr), .snoop_stall(snoop_stall),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data), .mem_wr_en(mem_wr_en),
    .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
    .status_valid(status_valid), .status_word(status_word), .done(done)
  );

  // backing memory and commit observer
  logic [31:0] bmem [256];
  int cyc = 0, nwr = 0, ndone = 0, stall_bad = 0, last_wr_cyc = 0, done_cyc = 0;
  assign mem_rd_data = bmem[mem_rd_addr];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 32'hA000_0000 + i;
    end else begin
      if (mem_wr_en) begin
        bmem[mem_wr_addr] <= mem_wr_data;
        nwr <= nwr + 1;
        last_wr_cyc <= cyc;
      end
      if (done) begin
        ndone <= ndone + 1;
        done_cyc <= cyc;
      end
    end
  end

  int n_chk = 0, n_bad = 0;

  function automatic logic [31:0] init_val(input int a);
    return 32'hA000_0000 + a;
  endfunction

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic idle_inputs();
    cmd_begin = 0; cmd_end = 0; cmd_abort = 0; evt_trap = 0; evt_debug = 0;
    req_valid = 0; req_write = 0; snoop_valid = 0; snoop_write = 0;
  endtask

  task automatic do_begin();
    cmd_begin = 1; step(); idle_inputs();
    chk(status_valid && status_word == 32'hFFFF_FFFF, "R1", "started status",
        status_word, 32'hFFFF_FFFF);
  endtask

  task automatic do_store(input logic [AW-1:0] a, input logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; step(); idle_inputs();
  endtask

  task automatic do_load(input logic [AW-1:0] a, input logic [31:0] exp, input string req);
    req_valid = 1; req_write = 0; req_addr = a; step(); idle_inputs();
    chk(rsp_valid && rsp_rdata == exp, req, "load data", rsp_rdata, exp);
  endtask

  task automatic expect_abort(input logic [31:0] exp, input string req);
    chk(status_valid && status_word == exp, req, "abort word", status_word, exp);
  endtask

  task automatic t_reset();
    chk(!status_valid && !done && !rsp_valid && !snoop_stall && req_ready, "R1",
        "reset outputs", {27'd0, status_valid, done, rsp_valid, snoop_stall, req_ready}, 32'h1);
  endtask

  task automatic t_passthrough();  // R11
    int w0;
    w0 = nwr;
    do_store(8'h10, 32'h1111_0010);
    chk(nwr == w0 + 1 && bmem[8'h10] == 32'h1111_0010, "R11", "write-through",
        bmem[8'h10], 32'h1111_0010);
    do_load(8'h10, 32'h1111_0010, "R11");
  endtask

  task automatic t_commit();  // R2, R8
    int w0, d0;
    do_begin();
    w0 = nwr;
    do_store(8'h20, 32'hC0DE_0020);
    do_store(8'h21, 32'hC0DE_0021);
    do_store(8'h22, 32'hC0DE_0022);
    chk(nwr == w0 && bmem[8'h21] == init_val(8'h21), "R2", "stores hidden",
        bmem[8'h21], init_val(8'h21));
    do_load(8'h21, 32'hC0DE_0021, "R2");
    do_load(8'h30, init_val(8'h30), "R2");
    d0 = ndone;
    cmd_end = 1;
    @(posedge clk);
    #1;
    idle_inputs();
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (!(mem_wr_en && snoop_stall)) stall_bad++;
    end
    repeat (4) step();
    chk(nwr == w0 + 3, "R8", "drained store count", nwr - w0, 3);
    chk(stall_bad == 0, "R8", "stall during drain", stall_bad, 0);
    chk(ndone == d0 + 1 && done_cyc == last_wr_cyc + 1, "R8", "done after last write",
        done_cyc - last_wr_cyc, 1);
    chk(bmem[8'h20] == 32'hC0DE_0020 && bmem[8'h22] == 32'hC0DE_0022, "R8",
        "committed data", bmem[8'h22], 32'hC0DE_0022);
  endtask

  task automatic t_explicit();  // R6, R7
    do_begin();
    do_store(8'h40, 32'hDEAD_0040);
    cmd_abort = 1; abort_code = 8'hFF; step(); idle_inputs();
    expect_abort(32'hFF00_0001, "R6");
    repeat (3) step();
    chk(bmem[8'h40] == init_val(8'h40), "R7", "memory kept", bmem[8'h40], init_val(8'h40));
    do_load(8'h40, init_val(8'h40), "R7");
  endtask

  task automatic t_conflicts();  // R3
    do_begin();
    do_store(8'h50, 32'h5050_5050);
    snoop_valid = 1; snoop_write = 0; snoop_addr = 8'h50; step(); idle_inputs();
    expect_abort(32'h0000_0002, "R3");
    do_begin();
    do_load(8'h51, init_val(8'h51), "R3");
    snoop_valid = 1; snoop_write = 0; snoop_addr = 8'h51; step(); idle_inputs();
    chk(!status_valid, "R3", "shared read no abort", status_valid, 0);
    snoop_valid = 1; snoop_write = 0; snoop_addr = 8'h77; step(); idle_inputs();
    chk(!status_valid, "R3", "untracked line no abort", status_valid, 0);
    snoop_valid = 1; snoop_write = 1; snoop_addr = 8'h51; step(); idle_inputs();
    expect_abort(32'h0000_0002, "R3");
  endtask

  task automatic t_capacity();  // R4
    do_begin();
    for (int i = 0; i < 8; i++) do_load(8'h60 + i[7:0], init_val(8'h60 + i), "R4");
    chk(!status_valid, "R4", "eight lines fit", status_valid, 0);
    req_valid = 1; req_write = 0; req_addr = 8'h68; step(); idle_inputs();
    expect_abort(32'h0000_0004, "R4");
    chk(!rsp_valid, "R4", "no response on overflow", rsp_valid, 0);
  endtask

  task automatic t_events();  // R5
    do_begin();
    evt_trap = 1; step(); idle_inputs();
    expect_abort(32'h0000_0010, "R5");
    do_begin();
    evt_debug = 1; step(); idle_inputs();
    expect_abort(32'h0000_0008, "R5");
  endtask

  task automatic t_end_snoop();  // R9
    int w0, d0;
    do_begin();
    do_store(8'h70, 32'h7070_7070);
    w0 = nwr; d0 = ndone;
    cmd_end = 1; snoop_valid = 1; snoop_write = 1; snoop_addr = 8'h70; step(); idle_inputs();
    expect_abort(32'h0000_0002, "R9");
    repeat (3) step();
    chk(nwr == w0 && ndone == d0 && bmem[8'h70] == init_val(8'h70), "R9", "no commit",
        bmem[8'h70], init_val(8'h70));
  endtask

  task automatic t_empty_commit();  // R8
    int w0;
    do_begin();
    do_load(8'h31, init_val(8'h31), "R8");
    w0 = nwr;
    cmd_end = 1; step(); idle_inputs();
    chk(done == 1'b1, "R8", "done next cycle", done, 1);
    step();
    chk(!done && nwr == w0, "R8", "single pulse no writes", nwr - w0, 0);
  endtask

  task automatic t_reuse();  // R10
    do_begin();
    for (int i = 0; i < 8; i++) do_store(8'h80 + i[7:0], 32'hBEEF_0000 + i);
    chk(!status_valid, "R10", "table cleared for reuse", status_valid, 0);
    cmd_end = 1; step(); idle_inputs();
    repeat (12) step();
    for (int i = 0; i < 8; i++)
      chk(bmem[8'h80 + i] == 32'hBEEF_0000 + i, "R10", "reused commit data",
          bmem[8'h80 + i], 32'hBEEF_0000 + i);
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1;
    step();
    t_reset();
    t_passthrough();
    t_commit();
    t_explicit();
    t_conflicts();
    t_capacity();
    t_events();
    t_end_snoop();
    t_empty_commit();
    t_reuse();
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule